// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous 16-bit DRAM whose row and column addresses share one 8-bit address bus. The host issues one request at a time (word address, write flag, two byte enables, write data) with a valid/ready handshake. Read data comes back with a one-cycle response pulse. Writes complete without a response.

The controller opens a row with the row strobe and leaves it open afterwards. Later requests to the same row become short column cycles. A request to another row first closes the open row for a precharge interval. Each byte lane has its own column strobe, so byte reads and byte writes need no read-modify-write.

A free-running timer marks a refresh as due. The controller then stops accepting requests, closes any open row and runs a CAS-before-RAS refresh cycle. Every strobe interval is a parameter counted in clock cycles.

Top module: `fpm_ctrl`

## Requirements
- R1: Request address bits 15:8 select the row, which is driven on `dram_addr` when the row strobe falls. Bits 7:0 select the column, which is driven on `dram_addr` when a column strobe falls.
- R2: `req_be[0]` enables column strobe `dram_cas_n[0]`, which carries data bits 7:0. `req_be[1]` enables `dram_cas_n[1]`, which carries bits 15:8. A write leaves the unselected lane of memory unchanged. A read returns zero in the unselected lane of `rsp_rdata`.
- R3: During a read column cycle, write enable is high and output enable is low. Data is sampled on the last cycle of the column strobe pulse. `rsp_valid` pulses for one cycle for each read and never for a write.
- R4: A write drives write enable low at least one cycle before the column strobe falls. The data bus is driven only while write enable is low, and never while output enable is low.
- R5: A request to the row that is already open issues only a column cycle; the row strobe does not fall again.
- R6: A request to a different row raises the row strobe for at least `T_RP` cycles before the new row is opened. Every other rise of the row strobe also lasts at least `T_RP` cycles.
- R7: A column strobe falls only after the row strobe has been low for at least `T_RCD` cycles. It stays low for at least `T_CAS` cycles. Between column cycles, the column strobes stay high for at least `T_CP` cycles.
- R8: A refresh starts every `REF_PERIOD` cycles, give or take the length of one access and one precharge. While a refresh is due, `req_ready` is low, and any open row is closed before the refresh starts.
- R9: In a refresh, both column strobes are low for at least `T_CSR` cycles before the row strobe falls. The row strobe then stays low for `T_RAS_REF` cycles.
- R10: After `PAGE_MAX` column cycles in one row, the row is closed. The next request to that row opens it again.
- R11: After reset, all strobes and write/output enables are high, the data bus is not driven, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_addr | input | 16 | Word address, row in upper byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte lane enables |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The hardest case to reach is a refresh that becomes due while a row is open and a row-miss request is already in flight. The controller must finish the column cycle, precharge, refresh, and then reopen a row, all without breaking any strobe interval. The bench shortens the refresh period to a few hundred cycles and runs random traffic over only four rows. This makes refresh collide often with open pages, page misses and the page-length limit. Directed sequences that start right after a refresh measure row activations exactly. A memory model in the bench checks every strobe interval.

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 8,
  parameter int DATA_W     = 16,
  parameter int T_RCD      = 3,
  parameter int T_CAS      = 2,
  parameter int T_CP       = 2,
  parameter int T_RP       = 3,
  parameter int T_CSR      = 1,
  parameter int T_RAS_REF  = 6,
  parameter int PAGE_MAX   = 256,
  parameter int REF_PERIOD = 3125
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic                     req_write,
  input  logic [1:0]               req_be,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [(ROW_W>COL_W ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                     dram_ras_n,
  output logic [1:0]               dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [DATA_W-1:0]        dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DATA_W-1:0]        dram_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int A_W    = ROW_W > COL_W ? ROW_W : COL_W;
  localparam int LANE_W = DATA_W / 2;
  localparam int M1     = T_RCD > T_CAS ? T_RCD : T_CAS;
  localparam int M2     = T_CP > T_RP ? T_CP : T_RP;
  localparam int M3     = T_CSR > T_RAS_REF ? T_CSR : T_RAS_REF;
  localparam int M12    = M1 > M2 ? M1 : M2;
  localparam int TMAX   = M12 > M3 ? M12 : M3;
  localparam int CNT_W  = $clog2(TMAX + 1);
  localparam int REF_W  = $clog2(REF_PERIOD + 1);
  localparam int PG_W   = $clog2(PAGE_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_CSU, S_CAS, S_CPR, S_PAGE, S_PRE, S_RCAS, S_RRAS, S_RREC
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wd_q;
  logic [REF_W-1:0]  ref_tmr;
  logic              ref_pend;
  logic [PG_W-1:0]   pg_cnt;
  logic              pre_to_row;

  wire accept    = req_valid && req_ready;
  wire hit       = req_addr[ADDR_W-1:COL_W] == row_q;
  wire cnt_done  = cnt == '0;
  wire col_phase = st inside {S_CSU, S_CAS, S_CPR};
  wire ref_cas   = st inside {S_RCAS, S_RRAS};
  wire [DATA_W-1:0] lane_mask = {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};

  assign req_ready     = (st == S_IDLE || st == S_PAGE) && !ref_pend;
  assign dram_addr     = col_phase ? A_W'(col_q) : A_W'(row_q);
  assign dram_ras_n    = !(st inside {S_ROW, S_CSU, S_CAS, S_CPR, S_PAGE, S_RRAS});
  assign dram_cas_n[0] = !((st == S_CAS && be_q[0]) || ref_cas);
  assign dram_cas_n[1] = !((st == S_CAS && be_q[1]) || ref_cas);
  assign dram_we_n     = !(wr_q && col_phase);
  assign dram_oe_n     = !(!wr_q && st == S_CAS);
  assign dram_dq_oe    = !dram_we_n;
  assign dram_dq_out   = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      be_q       <= '0;
      wd_q       <= '0;
      ref_tmr    <= REF_W'(REF_PERIOD - 1);
      ref_pend   <= 1'b0;
      pg_cnt     <= '0;
      pre_to_row <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!cnt_done) cnt <= cnt - 1'b1;
      if (accept) begin
        row_q <= req_addr[ADDR_W-1:COL_W];
        col_q <= req_addr[COL_W-1:0];
        wr_q  <= req_write;
        be_q  <= req_be;
        wd_q  <= req_wdata;
      end
      case (st)
        S_IDLE:
          if (ref_pend) begin
            st       <= S_RCAS;
            cnt      <= CNT_W'(T_CSR - 1);
            ref_pend <= 1'b0;
          end else if (accept) begin
            st     <= S_ROW;
            cnt    <= CNT_W'(T_RCD - 1);
            pg_cnt <= '0;
          end
        S_ROW: if (cnt_done) st <= S_CSU;
        S_CSU: begin
          st  <= S_CAS;
          cnt <= CNT_W'(T_CAS - 1);
        end
        S_CAS:
          if (cnt_done) begin
            if (!wr_q) begin
              rsp_rdata <= dram_dq_in & lane_mask;
              rsp_valid <= 1'b1;
            end
            st  <= S_CPR;
            cnt <= CNT_W'(T_CP - 1);
          end
        S_CPR:
          if (cnt_done) begin
            pg_cnt <= pg_cnt + 1'b1;
            if (pg_cnt == PG_W'(PAGE_MAX - 1)) begin
              st         <= S_PRE;
              pre_to_row <= 1'b0;
              cnt        <= CNT_W'(T_RP - 1);
            end else begin
              st <= S_PAGE;
            end
          end
        S_PAGE:
          if (ref_pend) begin
            st         <= S_PRE;
            pre_to_row <= 1'b0;
            cnt        <= CNT_W'(T_RP - 1);
          end else if (accept) begin
            if (hit) begin
              st <= S_CSU;
            end else begin
              st         <= S_PRE;
              pre_to_row <= 1'b1;
              cnt        <= CNT_W'(T_RP - 1);
            end
          end
        S_PRE:
          if (cnt_done) begin
            if (pre_to_row) begin
              st     <= S_ROW;
              cnt    <= CNT_W'(T_RCD - 1);
              pg_cnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        S_RCAS:
          if (cnt_done) begin
            st  <= S_RRAS;
            cnt <= CNT_W'(T_RAS_REF - 1);
          end
        S_RRAS:
          if (cnt_done) begin
            st  <= S_RREC;
            cnt <= CNT_W'(T_RP - 1);
          end
        S_RREC: if (cnt_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (ref_tmr == '0) begin
        ref_tmr  <= REF_W'(REF_PERIOD - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr - 1'b1;
      end
    end
  end

  logic [15:0] ras_hi_c, ras_lo_c, cas_hi_c, cas_lo_c;
  wire cas_any = dram_cas_n != 2'b11;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi_c <= 16'hFFFF;
      ras_lo_c <= '0;
      cas_hi_c <= 16'hFFFF;
      cas_lo_c <= '0;
    end else begin
      ras_hi_c <= dram_ras_n ? (ras_hi_c == 16'hFFFF ? ras_hi_c : ras_hi_c + 1'b1) : '0;
      ras_lo_c <= !dram_ras_n ? (ras_lo_c == 16'hFFFF ? ras_lo_c : ras_lo_c + 1'b1) : '0;
      cas_hi_c <= !cas_any ? (cas_hi_c == 16'hFFFF ? cas_hi_c : cas_hi_c + 1'b1) : '0;
      cas_lo_c <= cas_any ? (cas_lo_c == 16'hFFFF ? cas_lo_c : cas_lo_c + 1'b1) : '0;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(!dram_oe_n)); // R3
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cas_any) && !dram_we_n |-> $past(!dram_we_n)); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n) dram_dq_oe |-> dram_oe_n); // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(dram_ras_n) |-> ras_hi_c >= 16'(T_RP)); // R6
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n) $rose(cas_any) && !dram_ras_n |-> ras_lo_c >= 16'(T_RCD)); // R7
  AST_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $rose(cas_any) && !dram_ras_n |-> cas_hi_c >= 16'(T_CP)); // R7
  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_any) && !dram_ras_n |-> cas_lo_c >= 16'(T_CAS)); // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $fell(dram_ras_n) && cas_any |-> cas_lo_c >= 16'(T_CSR)); // R9
  AST_REF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) $rose(cas_any) && dram_ras_n |-> !$past(req_ready)); // R8
endmodule

// File: tb/fpm_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_ctrl_bench;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_CSR = 1, T_RAS_REF = 3;
  localparam int PAGE_MAX = 4, REF_PERIOD = 400, SLACK = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, rsp_valid;
  logic [15:0] req_addr, req_wdata, rsp_rdata, dram_dq_out, dram_dq_in;
  logic [1:0]  req_be, dram_cas_n;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;

  fpm_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR),
             .T_RAS_REF(T_RAS_REF), .PAGE_MAX(PAGE_MAX), .REF_PERIOD(REF_PERIOD)) u_fpm_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model: rows 0..15 only
  logic [15:0] mem [0:4095];
  logic [15:0] shadow [0:4095];
  logic [7:0]  m_row = '0, m_col = '0;
  int act_cnt = 0, ref_cnt = 0, last_ref = 0, min_gap = 1 << 30, max_gap = 0;
  int v_r1 = 0, v_r3 = 0, v_r4 = 0, v_r6 = 0, v_r7 = 0, v_r9 = 0;
  int ras_hi_c, ras_lo_c, cas_hi_c, cas_lo_c;
  bit p_ras, p_cas, p_we, in_ref;

  wire [11:0] m_idx = {m_row[3:0], m_col};

  always_comb begin
    dram_dq_in = 16'hA5A5;
    if (!dram_ras_n && !dram_oe_n) begin
      if (!dram_cas_n[0]) dram_dq_in[7:0]  = mem[m_idx][7:0];
      if (!dram_cas_n[1]) dram_dq_in[15:8] = mem[m_idx][15:8];
    end
  end

  always @(negedge clk) begin
    bit cas_lo;
    cas_lo = dram_cas_n != 2'b11;
    if (!rst_n) begin
      p_ras = 1; p_cas = 0; p_we = 1; in_ref = 0;
      ras_hi_c = 1000; ras_lo_c = 0; cas_hi_c = 1000; cas_lo_c = 0;
    end else begin
      if (p_ras && !dram_ras_n) begin
        if (cas_lo) begin
          if (ref_cnt > 0) begin
            if (cyc - last_ref < min_gap) min_gap = cyc - last_ref;
            if (cyc - last_ref > max_gap) max_gap = cyc - last_ref;
          end
          last_ref = cyc;
          ref_cnt++;
          in_ref = 1;
          if (cas_lo_c < T_CSR) v_r9++;
        end else begin
          m_row = dram_addr;
          act_cnt++;
          if (dram_addr >= 8'd16) v_r1++;
          if (ras_hi_c < T_RP) v_r6++;
        end
      end
      if (dram_ras_n) in_ref = 0;
      if (!p_cas && cas_lo && !dram_ras_n && !p_ras) begin
        m_col = dram_addr;
        if (ras_lo_c < T_RCD || cas_hi_c < T_CP) v_r7++;
        if (!dram_we_n) begin
          if (p_we || !dram_dq_oe) v_r4++;
          if (!dram_cas_n[0]) mem[{m_row[3:0], dram_addr}][7:0]  = dram_dq_out[7:0];
          if (!dram_cas_n[1]) mem[{m_row[3:0], dram_addr}][15:8] = dram_dq_out[15:8];
        end
      end
      if (p_cas && !cas_lo && !dram_ras_n && cas_lo_c < T_CAS) v_r7++;
      if (dram_dq_oe && !dram_oe_n) v_r4++;
      if (cas_lo && !dram_ras_n && !in_ref && dram_we_n && dram_oe_n) v_r3++;
      ras_hi_c = dram_ras_n ? ras_hi_c + 1 : 0;
      ras_lo_c = dram_ras_n ? 0 : ras_lo_c + 1;
      cas_hi_c = cas_lo ? 0 : cas_hi_c + 1;
      cas_lo_c = cas_lo ? cas_lo_c + 1 : 0;
      p_ras = dram_ras_n; p_cas = cas_lo; p_we = dram_we_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a, input logic [1:0] be);
    logic [15:0] w = shadow[{a[11:8], a[7:0]}];
    return w & {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic access(input logic [15:0] a, input bit w, input logic [1:0] be,
                        input logic [15:0] d, output logic [15:0] rd);
    @(negedge clk);
    req_addr = a; req_write = w; req_be = be; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = '0;
    if (w) begin
      if (be[0]) shadow[{a[11:8], a[7:0]}][7:0]  = d[7:0];
      if (be[1]) shadow[{a[11:8], a[7:0]}][15:8] = d[15:8];
    end else begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end
  endtask

  task automatic wait_refresh();
    int r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd, a, d;
    logic [1:0]  be;
    bit          w;
    int          a0;
    void'($urandom(32'd1729));
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; shadow[i] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_be = 2'b11; req_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(dram_ras_n == 1'b1, "R11", "ras_n after reset", dram_ras_n, 1);
    chk(dram_cas_n == 2'b11, "R11", "cas_n after reset", dram_cas_n, 3);
    chk(dram_we_n && dram_oe_n, "R11", "we_n&oe_n after reset", dram_we_n & dram_oe_n, 1);
    chk(!dram_dq_oe, "R11", "dq_oe after reset", dram_dq_oe, 0);
    chk(!rsp_valid, "R11", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready, "R11", "req_ready after reset", req_ready, 1);

    // R1 / R2 / R3 directed
    wait_refresh();
    access(16'h0312, 1, 2'b11, 16'hBEEF, rd);
    access(16'h0312, 0, 2'b11, 16'h0, rd);
    chk(rd == 16'hBEEF, "R3", "word read", rd, 16'hBEEF);
    chk(m_row == 8'h03, "R1", "row on address pins", m_row, 3);
    chk(m_col == 8'h12, "R1", "column on address pins", m_col, 8'h12);
    access(16'h0312, 1, 2'b01, 16'h1234, rd);
    access(16'h0312, 0, 2'b11, 16'h0, rd);
    chk(rd == 16'hBE34, "R2", "lower-lane write keeps upper", rd, 16'hBE34);
    wait_refresh();
    access(16'h0312, 0, 2'b10, 16'h0, rd);
    chk(rd == 16'hBE00, "R2", "upper-lane read masks lower", rd, 16'hBE00);
    access(16'h0312, 0, 2'b01, 16'h0, rd);
    chk(rd == 16'h0034, "R2", "lower-lane read masks upper", rd, 16'h0034);

    // R5 page hit
    wait_refresh();
    a0 = act_cnt;
    for (int i = 0; i < 3; i++) access({8'h05, 8'(i * 7)}, 0, 2'b11, 16'h0, rd);
    chk(act_cnt - a0 == 1, "R5", "activations for 3 same-row reads", act_cnt - a0, 1);

    // R10 page limit
    wait_refresh();
    a0 = act_cnt;
    for (int i = 0; i < PAGE_MAX + 2; i++) access({8'h06, 8'(i)}, 0, 2'b11, 16'h0, rd);
    chk(act_cnt - a0 == 2, "R10", "activations for PAGE_MAX+2 reads", act_cnt - a0, 2);

    // R6 page miss
    wait_refresh();
    a0 = act_cnt;
    access(16'h0100, 1, 2'b11, 16'h1111, rd);
    access(16'h0200, 1, 2'b11, 16'h2222, rd);
    access(16'h0100, 0, 2'b11, 16'h0, rd);
    chk(act_cnt - a0 == 3, "R6", "activations for row ping-pong", act_cnt - a0, 3);
    chk(rd == 16'h1111, "R6", "data across row change", rd, 16'h1111);

    // random traffic over four rows
    for (int i = 0; i < 400; i++) begin
      a  = {8'($urandom % 4), 8'($urandom)};
      w  = 1'($urandom);
      be = 2'($urandom % 3 + 1);
      d  = 16'($urandom);
      access(a, w, be, d, rd);
      if (!w) chk(rd == exp_read(a, be), be == 2'b11 ? "R3" : "R2", "random read", rd, exp_read(a, be));
    end

    repeat (20) @(negedge clk);
    chk(v_r1 == 0, "R1", "row outside modelled range", v_r1, 0);
    chk(v_r3 == 0, "R3", "read cycle without oe", v_r3, 0);
    chk(v_r4 == 0, "R4", "early write / bus drive violations", v_r4, 0);
    chk(v_r6 == 0, "R6", "precharge violations", v_r6, 0);
    chk(v_r7 == 0, "R7", "column timing violations", v_r7, 0);
    chk(v_r9 == 0, "R9", "CBR ordering violations", v_r9, 0);
    chk(ref_cnt >= cyc / REF_PERIOD - 1, "R8", "refresh count", ref_cnt, cyc / REF_PERIOD - 1);
    chk(max_gap <= REF_PERIOD + SLACK, "R8", "max refresh gap", max_gap, REF_PERIOD + SLACK);
    chk(min_gap >= REF_PERIOD - SLACK, "R8", "min refresh gap", min_gap, REF_PERIOD - SLACK);
    summary();
    $finish;
  end
endmodule